// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This block is the decimal-correction datapath of a byte-oriented integer core. After a binary add, subtract or multiply has left its result in the accumulator pair (high byte AH, low byte AL), the unit applies one of six corrections, chosen by a 3-bit operation code. The incoming half-carry flag AF and carry flag CF also feed the correction. It returns the corrected pair and a fresh set of AF, CF, PF, SF and ZF flags.

The operations are the unpacked (one digit per byte) add and subtract corrections, the packed (two digits per byte) add and subtract corrections, the multiply-unpack split and the divide-prepare merge. A one-cycle `start` strobe captures the operands. The registered result appears with a one-cycle `done` strobe on the next clock and holds until the next `start`.

Top module: `dec_adjust_unit`

## Requirements
- R1: While `rst` is high, every output, including `done`, is 0 after the clock edge, even when `start` is high.
- R2: `done` is high for exactly the cycle after each cycle in which `start` was high. Without `start`, all result and flag outputs hold their values.
- R3: Code 0 (unpacked add): when AL[3:0] > 9 or AF is set, AL becomes (AL + 6) & 0x0F, AH becomes AH + 1 modulo 256, and AF and CF are both set.
- R4: Codes 0 and 1, with AL[3:0] <= 9 and AF clear: AL becomes AL & 0x0F, AH is unchanged, and AF and CF are both cleared. For codes 0 and 1, AL[7:4] of the result is always 0.
- R5: Code 1 (unpacked subtract): when AL[3:0] > 9 or AF is set, AL becomes (AL - 6) & 0x0F, AH becomes AH - 1 modulo 256, and AF and CF are both set.
- R6: Code 2 (packed add) runs two steps and leaves AH unchanged. Step 1: if AL[3:0] > 9 or AF is set, add 6 modulo 256 and set AF; otherwise clear AF. Step 2: if the step-1 value is above 0x9F or CF is set, add 0x60 modulo 256 and set CF; otherwise clear CF.
- R7: Code 3 (packed subtract) is code 2 with 6 and 0x60 subtracted modulo 256 instead of added.
- R8: Code 4 (multiply-unpack): AH becomes AL / 10 and AL becomes AL mod 10. AF and CF are cleared.
- R9: Code 5 (divide-prepare): AL becomes (AH * 10 + AL) mod 256 and AH becomes 0. AF and CF are cleared.
- R10: For codes 2 to 5, PF is 1 when the final AL has an even number of ones, SF equals AL[7] and ZF is 1 when AL is 0. For codes 0 and 1, PF, SF and ZF are 0.
- R11: Codes 6 and 7 pass AH and AL through unchanged and clear all five flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and run the selected correction |
| op_in | input | 3 | Operation code (0..7) |
| ah_in | input | 8 | High accumulator byte |
| al_in | input | 8 | Low accumulator byte |
| af_in | input | 1 | Incoming half-carry flag |
| cf_in | input | 1 | Incoming carry flag |
| ah_out | output | 8 | Corrected high byte |
| al_out | output | 8 | Corrected low byte |
| af_out | output | 1 | Resulting half-carry flag |
| cf_out | output | 1 | Resulting carry flag |
| pf_out | output | 1 | Resulting even-parity flag |
| sf_out | output | 1 | Resulting sign flag |
| zf_out | output | 1 | Resulting zero flag |
| done | output | 1 | Result valid strobe, one cycle after `start` |

## Verification
Both packed correction steps can fire within one operation. The low-digit fix from step 1 can carry into the high digit and push the step-1 value above 0x9F, and step 2 then fires on that value. A second case is 0xFA, where step 1 wraps the value to zero and step 2 does not fire unless CF comes in set. Every code is swept over all 256 AL values and all four AF/CF combinations, with starts issued back to back and with idle gaps. Each result is judged against a reference model that the bench derives from the requirements.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int DIG_W  = 4;
  localparam int BYTE_W = 2 * DIG_W;
  localparam int RADIX  = 10;
  localparam int OPC_W  = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_UADD  = 3'd0,
    OP_USUB  = 3'd1,
    OP_PADD  = 3'd2,
    OP_PSUB  = 3'd3,
    OP_MUNPK = 3'd4,
    OP_DPREP = 3'd5
  } dau_op_t;

  typedef struct packed {
    logic [BYTE_W-1:0] ah;
    logic [BYTE_W-1:0] al;
    logic              af;
    logic              cf;
    logic              pf;
    logic              sf;
    logic              zf;
  } dau_res_t;
endpackage

// File: rtl/dau_unpacked.sv
module dau_unpacked #(
  parameter int DIG_W = dau_pkg::DIG_W,
  parameter int RADIX = dau_pkg::RADIX
) (
  input  logic               sub,
  input  logic [2*DIG_W-1:0] ah,
  input  logic [2*DIG_W-1:0] al,
  input  logic               af,
  output logic [2*DIG_W-1:0] ah_o,
  output logic [2*DIG_W-1:0] al_o,
  output logic               adj
);
  localparam int W = 2 * DIG_W;
  localparam logic [W-1:0] PAD   = W'((1 << DIG_W) - RADIX);
  localparam logic [W-1:0] ONE   = W'(1);
  localparam logic [DIG_W-1:0] MAXD = DIG_W'(RADIX - 1);

  logic [W-1:0] al_fix;

  always_comb begin
    adj    = (al[DIG_W-1:0] > MAXD) || af;
    al_fix = al;
    ah_o   = ah;
    if (adj) begin
      al_fix = sub ? (al - PAD) : (al + PAD);
      ah_o   = sub ? (ah - ONE) : (ah + ONE);
    end
    al_o = {{DIG_W{1'b0}}, al_fix[DIG_W-1:0]};
  end
endmodule

// File: rtl/dau_packed.sv
module dau_packed #(
  parameter int DIG_W = dau_pkg::DIG_W,
  parameter int RADIX = dau_pkg::RADIX
) (
  input  logic               sub,
  input  logic [2*DIG_W-1:0] al,
  input  logic               af,
  input  logic               cf,
  output logic [2*DIG_W-1:0] al_o,
  output logic               af_o,
  output logic               cf_o
);
  localparam int W = 2 * DIG_W;
  localparam int PADI = (1 << DIG_W) - RADIX;
  localparam logic [W-1:0] PAD_LO = W'(PADI);
  localparam logic [W-1:0] PAD_HI = W'(PADI << DIG_W);
  localparam logic [DIG_W-1:0] MAXD = DIG_W'(RADIX - 1);
  // largest value whose upper digit is still a legal decimal digit
  localparam logic [W-1:0] HI_LIM = W'(((RADIX - 1) << DIG_W) | ((1 << DIG_W) - 1));

  logic [W-1:0] stage1;

  always_comb begin
    // low digit step
    af_o   = (al[DIG_W-1:0] > MAXD) || af;
    stage1 = al;
    if (af_o) stage1 = sub ? (al - PAD_LO) : (al + PAD_LO);
    // high digit step, tested on the step-1 value
    cf_o = (stage1 > HI_LIM) || cf;
    al_o = stage1;
    if (cf_o) al_o = sub ? (stage1 - PAD_HI) : (stage1 + PAD_HI);
  end
endmodule

// File: rtl/dau_scale.sv
module dau_scale #(
  parameter int W     = dau_pkg::BYTE_W,
  parameter int RADIX = dau_pkg::RADIX
) (
  input  logic [W-1:0] ah,
  input  logic [W-1:0] al,
  output logic [W-1:0] split_hi,
  output logic [W-1:0] split_lo,
  output logic [W-1:0] merge_lo
);
  localparam logic [W-1:0] RDX = W'(RADIX);

  always_comb begin
    split_hi = al / RDX;
    split_lo = al % RDX;
    merge_lo = (ah * RDX) + al;
  end
endmodule

// File: rtl/dau_flags.sv
module dau_flags #(
  parameter int W = dau_pkg::BYTE_W
) (
  input  logic         en,
  input  logic [W-1:0] val,
  output logic         pf,
  output logic         sf,
  output logic         zf
);
  always_comb begin
    pf = en & ~(^val);
    sf = en & val[W-1];
    zf = en & (val == '0);
  end
endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit
  import dau_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [OPC_W-1:0]       op_in,
  input  logic [BYTE_W-1:0]      ah_in,
  input  logic [BYTE_W-1:0]      al_in,
  input  logic                   af_in,
  input  logic                   cf_in,
  output logic [BYTE_W-1:0]      ah_out,
  output logic [BYTE_W-1:0]      al_out,
  output logic                   af_out,
  output logic                   cf_out,
  output logic                   pf_out,
  output logic                   sf_out,
  output logic                   zf_out,
  output logic                   done
);
  logic [BYTE_W-1:0] un_ah, un_al, pk_al, sp_hi, sp_lo, mg_lo;
  logic              un_adj, pk_af, pk_cf;
  logic              is_sub, flag_en, f_pf, f_sf, f_zf;
  dau_res_t          res_d, res_q;
  logic              done_q;
  dau_op_t           op;

  assign op     = dau_op_t'(op_in);
  assign is_sub = op_in[0];

  dau_unpacked #(.DIG_W(DIG_W), .RADIX(RADIX)) u_unp (
    .sub(is_sub), .ah(ah_in), .al(al_in), .af(af_in),
    .ah_o(un_ah), .al_o(un_al), .adj(un_adj)
  );

  dau_packed #(.DIG_W(DIG_W), .RADIX(RADIX)) u_pck (
    .sub(is_sub), .al(al_in), .af(af_in), .cf(cf_in),
    .al_o(pk_al), .af_o(pk_af), .cf_o(pk_cf)
  );

  dau_scale #(.W(BYTE_W), .RADIX(RADIX)) u_scl (
    .ah(ah_in), .al(al_in),
    .split_hi(sp_hi), .split_lo(sp_lo), .merge_lo(mg_lo)
  );

  always_comb begin
    res_d    = '0;
    flag_en  = 1'b0;
    res_d.ah = ah_in;
    res_d.al = al_in;
    case (op)
      OP_UADD, OP_USUB: begin
        res_d.ah = un_ah;
        res_d.al = un_al;
        res_d.af = un_adj;
        res_d.cf = un_adj;
      end
      OP_PADD, OP_PSUB: begin
        res_d.al = pk_al;
        res_d.af = pk_af;
        res_d.cf = pk_cf;
        flag_en  = 1'b1;
      end
      OP_MUNPK: begin
        res_d.ah = sp_hi;
        res_d.al = sp_lo;
        flag_en  = 1'b1;
      end
      OP_DPREP: begin
        res_d.ah = '0;
        res_d.al = mg_lo;
        flag_en  = 1'b1;
      end
      default: ;
    endcase
    res_d.pf = f_pf;
    res_d.sf = f_sf;
    res_d.zf = f_zf;
  end

  dau_flags #(.W(BYTE_W)) u_flg (
    .en(flag_en), .val(res_d.al), .pf(f_pf), .sf(f_sf), .zf(f_zf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start;
      if (start) res_q <= res_d;
    end
  end

  assign ah_out = res_q.ah;
  assign al_out = res_q.al;
  assign af_out = res_q.af;
  assign cf_out = res_q.cf;
  assign pf_out = res_q.pf;
  assign sf_out = res_q.sf;
  assign zf_out = res_q.zf;
  assign done   = done_q;
endmodule

// File: rtl/dau_chk.sv
module dau_chk
  import dau_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic [OPC_W-1:0]       op_in,
  input logic [BYTE_W-1:0]      ah_in,
  input logic [BYTE_W-1:0]      al_in,
  input logic                   af_in,
  input logic                   cf_in,
  input logic [BYTE_W-1:0]      ah_out,
  input logic [BYTE_W-1:0]      al_out,
  input logic                   af_out,
  input logic                   cf_out,
  input logic                   pf_out,
  input logic                   sf_out,
  input logic                   zf_out,
  input logic                   done
);
  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  // R2
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(ah_out) && $stable(al_out) && $stable(af_out) && $stable(cf_out)));

  // R4
  unpacked_high_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (op_in == 3'd0 || op_in == 3'd1)) |=>
      (al_out[7:4] == 4'd0 && af_out == cf_out && !pf_out && !sf_out && !zf_out));

  // R4
  unpacked_keep_ah_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op_in == 3'd0 && al_in[3:0] <= 4'd9 && !af_in) |=>
      (ah_out == $past(ah_in) && !cf_out));

  // R8
  split_digit_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op_in == 3'd4) |=> (al_out < 8'd10 && ah_out < 8'd26 && !cf_out));

  // R9
  merge_clears_ah_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op_in == 3'd5) |=> (ah_out == 8'd0 && zf_out == (al_out == 8'd0)));

  // R6
  packed_keeps_ah_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (op_in == 3'd2 || op_in == 3'd3)) |=> (ah_out == $past(ah_in)));
endmodule

bind dec_adjust_unit dau_chk u_chk (.*);

// File: tb/dec_adjust_unit_tb.sv
module dec_adjust_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] op_in = '0;
  logic [7:0] ah_in = '0, al_in = '0;
  logic       af_in = 1'b0, cf_in = 1'b0;
  logic [7:0] ah_out, al_out;
  logic       af_out, cf_out, pf_out, sf_out, zf_out, done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] ah;
    logic [7:0] al;
    logic       af, cf, pf, sf, zf;
    int         req;
  } exp_t;

  exp_t sb[$];
  exp_t last;

  always #10 clk = ~clk;  // 50 MHz

  dec_adjust_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .op_in(op_in),
    .ah_in(ah_in), .al_in(al_in), .af_in(af_in), .cf_in(cf_in),
    .ah_out(ah_out), .al_out(al_out), .af_out(af_out), .cf_out(cf_out),
    .pf_out(pf_out), .sf_out(sf_out), .zf_out(zf_out), .done(done)
  );

  function automatic exp_t model(input int op, input int ah, input int al,
                                 input int af, input int cf);
    exp_t e;
    int   v;
    bit   fl;
    e.ah = 8'(ah); e.al = 8'(al);
    e.af = 0; e.cf = 0; e.pf = 0; e.sf = 0; e.zf = 0;
    fl = 0;
    case (op)
      0, 1: begin
        if ((al % 16) > 9 || af != 0) begin
          v    = (op == 0) ? al + 6 : al - 6;
          e.al = 8'(v & 15);
          e.ah = 8'((op == 0) ? ah + 1 : ah - 1);
          e.af = 1; e.cf = 1;
          e.req = (op == 0) ? 3 : 5;       // R3 / R5
        end else begin
          e.al = 8'(al & 15);
          e.req = 4;                       // R4
        end
      end
      2, 3: begin
        v = al;
        if ((al % 16) > 9 || af != 0) begin
          v = ((op == 2) ? v + 6 : v - 6) & 255; e.af = 1;
        end
        if (v > 159 || cf != 0) begin
          v = ((op == 2) ? v + 96 : v - 96) & 255; e.cf = 1;
        end
        e.al = 8'(v); fl = 1;
        e.req = (op == 2) ? 6 : 7;         // R6 / R7
      end
      4: begin
        e.ah = 8'(al / 10); e.al = 8'(al % 10); fl = 1;
        e.req = 8;                         // R8
      end
      5: begin
        e.al = 8'((ah * 10 + al) & 255); e.ah = 0; fl = 1;
        e.req = 9;                         // R9
      end
      default: e.req = 11;                 // R11
    endcase
    if (fl) begin                          // R10
      e.pf = ($countones(e.al) % 2) == 0;
      e.sf = e.al[7];
      e.zf = (e.al == 0);
    end
    return e;
  endfunction

  task automatic issue(input int op, input int ah, input int al,
                       input int af, input int cf);
    @(negedge clk);
    op_in = 3'(op); ah_in = 8'(ah); al_in = 8'(al);
    af_in = 1'(af); cf_in = 1'(cf); start = 1'b1;
    sb.push_back(model(op, ah, al, af, cf));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !finished && done) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: done=1 with no pending operation, expected done=0");
      end else begin
        e = sb.pop_front();
        last = e;
        if ({ah_out, al_out, af_out, cf_out} !== {e.ah, e.al, e.af, e.cf}) begin
          fails++;
          $display("FAIL R%0d: ah/al/af/cf actual %h/%h/%b/%b expected %h/%h/%b/%b",
                   e.req, ah_out, al_out, af_out, cf_out, e.ah, e.al, e.af, e.cf);
        end
        checks++;
        if ({pf_out, sf_out, zf_out} !== {e.pf, e.sf, e.zf}) begin
          fails++;
          $display("FAIL R10 (op of R%0d): pf/sf/zf actual %b%b%b expected %b%b%b al=%h",
                   e.req, pf_out, sf_out, zf_out, e.pf, e.sf, e.zf, e.al);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: run exceeded 200000 cycles, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check_hold(input string tag);
    checks++;
    if (done !== 1'b0 || ah_out !== last.ah || al_out !== last.al ||
        af_out !== last.af || cf_out !== last.cf) begin
      fails++;
      $display("FAIL %s: idle done=%b ah/al=%h/%h expected done=0 ah/al=%h/%h",
               tag, done, ah_out, al_out, last.ah, last.al);
    end
  endtask

  initial begin
    // R1: reset holds outputs at zero even with start high
    start = 1'b1; op_in = 3'd4; al_in = 8'h99; ah_in = 8'h12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({ah_out, al_out, af_out, cf_out, pf_out, sf_out, zf_out, done} !== '0) begin
      fails++;
      $display("FAIL R1: outputs during reset actual %h%h %b%b%b%b%b %b expected all 0",
               ah_out, al_out, af_out, cf_out, pf_out, sf_out, zf_out, done);
    end
    start = 1'b0;
    rst = 1'b0;
    idle(2);
    checks++;
    if (done !== 1'b0) begin
      fails++;
      $display("FAIL R2: done after reset without start actual %b expected 0", done);
    end

    // Directed corners: both packed steps together, wrap at 0xFA
    issue(2, 8'h00, 8'h9A, 0, 0);  // R6: 0x9A -> 0x00, CF=1, ZF=1
    issue(2, 8'h00, 8'hFA, 0, 0);  // R6: wraps to 0x00, CF stays 0
    issue(3, 8'h00, 8'h0F, 0, 1);  // R7: both steps subtract
    issue(5, 8'h19, 8'h07, 0, 0);  // R9: 250+7 truncates
    issue(0, 8'hFF, 8'h0A, 0, 0);  // R3: AH wraps to 0
    issue(1, 8'h00, 8'h03, 1, 0);  // R5: AH wraps to FF
    idle(3);
    check_hold("R2");

    // Exhaustive sweep, back-to-back with periodic gaps
    for (int op = 0; op < 8; op++) begin
      for (int al = 0; al < 256; al++) begin
        for (int f = 0; f < 4; f++) begin
          issue(op, (al * 7 + op * 37 + f * 11) & 255, al, f & 1, f >> 1);
          if (((al + f) % 13) == 0) idle(1);
        end
      end
      idle(3);
      check_hold("R2");  // R11 codes included: held after idle
    end

    idle(2);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d results never signalled, expected 0", sb.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule